// File: doc/BRIEF.md
# Mode-Switchable Symmetric FIR Channel Filter

This block is one linear-phase channel filter of a multi-band audio filter bank. Each strobe on the input brings one signed sample at the channel's own decimated rate. The block answers each accepted sample with one filtered, rounded and saturated sample and a one-cycle valid pulse. The filter length is picked at run time by a mode code so that one channel can serve the 4-, 6- and 8-channel operating points of the bank. Because the impulse response is symmetric, only half of the coefficients are stored. Each mirrored pair of delayed samples is summed before it is multiplied, so there are half as many products as taps.

The products are accumulated one per clock cycle. A sample therefore takes half the selected tap count in cycles, which is far shorter than the interval between samples at audio rates. A strobe that arrives while a result is still being accumulated is dropped and recorded in a sticky overrun flag. An enable input idles the channel when the selected mode leaves it unused. While it is low, the delay line and output hold and no valid pulse is produced. A parameter builds a reduced variant that offers only the two longer lengths, or a fixed variant that always uses the longest length.

Top module: `fold_fir`

## Requirements
- R1: With `VARIANT`=0, `mode` 0 selects 14 taps, 1 selects 16 taps, and 2 or 3 selects 20 taps. The length is latched when a sample is accepted.
- R2: Half-coefficient k (signed 8-bit) is written at `coef_addr` k. For length N the result is acc = sum over k < N/2 of h[k]·(x[n−k] + x[n−(N−1−k)]), where x[n] is the newest accepted sample. Delayed samples at index N or beyond contribute nothing. Writes to addresses 10 or above are ignored.
- R3: `out_data` = floor((acc + 64) / 128), clamped to the range −256..255.
- R4: `out_valid` is a one-cycle pulse that rises N/2 clock edges after the edge that accepts the sample. There is exactly one pulse per accepted sample, and `out_data` changes only together with that pulse.
- R5: While `en` is low, input strobes are ignored, the delay line and `out_data` hold, and `out_valid` stays low.
- R6: A strobe that arrives while the previous sample is still being accumulated (at the N/2 edges after the accepting edge) is dropped and not shifted into the delay line. It sets `overrun`, which then stays set until reset.
- R7: `VARIANT`=1 maps `mode` 0 to 16 taps and keeps modes 1 to 3 as in R1. `VARIANT`=2 always uses 20 taps.
- R8: Reset clears the delay line, the coefficients, `out_data`, `out_valid` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| mode | input | 2 | Length select code |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Half-coefficient index |
| coef_data | input | 8 | Signed coefficient value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 9 | Signed input sample |
| out_valid | output | 1 | Result pulse |
| out_data | output | 9 | Signed filtered sample |
| overrun | output | 1 | Sticky dropped-strobe flag |

## Verification
The bench sweeps every mode on all three variants at once. It uses impulses and mixed sample streams, so a wrong mirror index or a tap left active beyond the selected length shows up as a wrong output value. Full-scale inputs with maximal coefficients, together with small values near the rounding point, catch missing saturation and truncation used in place of rounding. The latency of the valid pulse is measured against half the tap count, which exposes an off-by-one in the accumulation loop. A disabled strobe and a strobe that arrives while the filter is busy are each followed by a normal sample; a design that let either sample into the delay line would then produce a wrong result.

// File: rtl/fold_fir.sv
module fold_fir #(
  parameter int DW      = 9,
  parameter int CW      = 8,
  parameter int L4      = 14,
  parameter int L6      = 16,
  parameter int L8      = 20,
  parameter int VARIANT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           mode,
  input  logic                 coef_we,
  input  logic [3:0]           coef_addr,
  input  logic signed [CW-1:0] coef_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic                 overrun
);
  localparam int NH = L8 / 2;
  localparam int HW = $clog2(NH + 1);
  localparam int IW = $clog2(L8);
  localparam int AW = DW + CW + 1 + $clog2(NH);
  localparam logic signed [AW-1:0] RND  = AW'(1 << (CW - 2));
  localparam logic signed [AW-1:0] OMAX = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

  logic signed [CW-1:0] h   [NH];
  logic signed [DW-1:0] dly [L8];
  logic                 busy;
  logic [HW-1:0]        idx, nh_q, nh_sel;
  logic [IW-1:0]        pidx;
  logic signed [AW-1:0] acc, acc_nxt, rsh;
  logic signed [DW:0]   pair;
  logic signed [CW+DW:0] prod;
  logic signed [DW-1:0] res;

  always_comb begin
    if (VARIANT == 2)      nh_sel = HW'(L8 / 2);
    else if (mode == 2'd0) nh_sel = (VARIANT == 1) ? HW'(L6 / 2) : HW'(L4 / 2);
    else if (mode == 2'd1) nh_sel = HW'(L6 / 2);
    else                   nh_sel = HW'(L8 / 2);
  end

  assign pidx    = IW'({nh_q, 1'b0}) - IW'(1) - IW'(idx);
  assign pair    = {dly[idx][DW-1], dly[idx]} + {dly[pidx][DW-1], dly[pidx]};
  assign prod    = h[idx] * pair;
  assign acc_nxt = acc + AW'(prod);
  assign rsh     = (acc_nxt + RND) >>> (CW - 1);
  assign res     = (rsh > OMAX) ? OMAX[DW-1:0] :
                   (rsh < OMIN) ? OMIN[DW-1:0] : rsh[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NH; i++) h[i] <= '0;
      for (int i = 0; i < L8; i++) dly[i] <= '0;
      busy      <= 1'b0;
      idx       <= '0;
      nh_q      <= HW'(L8 / 2);
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (coef_we && (int'(coef_addr) < NH)) h[coef_addr] <= coef_data;
      if (en) begin
        if (in_valid) begin
          if (busy) overrun <= 1'b1;
          else begin
            dly[0] <= in_data;
            for (int i = 1; i < L8; i++) dly[i] <= dly[i-1];
            busy <= 1'b1;
            idx  <= '0;
            acc  <= '0;
            nh_q <= nh_sel;
          end
        end
        if (busy) begin
          acc <= acc_nxt;
          idx <= idx + HW'(1);
          if (idx == nh_q - HW'(1)) begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
            out_data  <= res;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       in_valid,
  input logic       out_valid,
  input logic [8:0] out_data,
  input logic       overrun
);
  // R4
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R6
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(in_valid));
endmodule

bind fold_fir fold_fir_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
);

// File: tb/fold_fir_tb.sv
module fold_fir_tb;
  logic clk = 0, rst_n = 0, en = 1, coef_we = 0, in_valid = 0;
  logic [1:0] mode = 0;
  logic [3:0] coef_addr = 0;
  logic signed [7:0] coef_data = 0;
  logic signed [8:0] in_data = 0;
  logic ov [3];
  logic signed [8:0] od [3];
  logic ovr [3];

  int nchk = 0, nfail = 0, cyc = 0;
  int vcnt [3], vcyc [3];
  int cap [3];
  int hc [10];
  int hist [20];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fold_fir #(.VARIANT(0)) u_dut (.clk, .rst_n, .en, .mode, .coef_we, .coef_addr,
    .coef_data, .in_valid, .in_data, .out_valid(ov[0]), .out_data(od[0]), .overrun(ovr[0]));
  fold_fir #(.VARIANT(1)) u_red (.clk, .rst_n, .en, .mode, .coef_we, .coef_addr,
    .coef_data, .in_valid, .in_data, .out_valid(ov[1]), .out_data(od[1]), .overrun(ovr[1]));
  fold_fir #(.VARIANT(2)) u_fix (.clk, .rst_n, .en, .mode, .coef_we, .coef_addr,
    .coef_data, .in_valid, .in_data, .out_valid(ov[2]), .out_data(od[2]), .overrun(ovr[2]));

  initial for (int i = 0; i < 3; i++) begin vcnt[i] = 0; vcyc[i] = 0; cap[i] = 0; end

  always @(negedge clk)
    for (int i = 0; i < 3; i++)
      if (ov[i]) begin cap[i] = od[i]; vcnt[i]++; vcyc[i] = cyc; end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ntaps(int inst, int m);
    if (inst == 2) return 20;
    if (inst == 1) return (m <= 1) ? 16 : 20;
    return (m == 0) ? 14 : (m == 1) ? 16 : 20;
  endfunction

  function automatic int model(int n);
    int s = 0, r;
    for (int k = 0; k < n / 2; k++) s += hc[k] * (hist[k] + hist[n-1-k]);
    r = (s + 64) >>> 7;
    if (r > 255) r = 255;
    if (r < -256) r = -256;
    return r;
  endfunction

  task automatic wr(int a, int v);
    @(negedge clk); coef_we = 1; coef_addr = 4'(a); coef_data = 8'(v);
    @(negedge clk); coef_we = 0;
  endtask

  task automatic hist_push(int x);
    for (int i = 19; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
  endtask

  task automatic push(int x, string req);
    int b [3];
    int c0;
    for (int i = 0; i < 3; i++) b[i] = vcnt[i];
    @(negedge clk); in_valid = 1; in_data = 9'(x);
    @(negedge clk); in_valid = 0; c0 = cyc;
    hist_push(x);
    repeat (12) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk({req, " R4 one pulse"}, vcnt[i] - b[i], 1);
      chk({req, " value"}, cap[i], model(ntaps(i, int'(mode))));
      chk("R4 latency", vcyc[i] - c0, ntaps(i, int'(mode)) / 2);
    end
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 20; i++) hist[i] = 0;
    for (int i = 0; i < 10; i++) hc[i] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int b [3];
    int keep [3];
    do_reset();
    // R8 reset state
    for (int i = 0; i < 3; i++) begin
      chk("R8 out_valid", int'(ov[i]), 0);
      chk("R8 out_data", int'(od[i]), 0);
      chk("R8 overrun", int'(ovr[i]), 0);
    end

    // R1 R2 R7 sweep of modes with impulses and mixed streams
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int k = 0; k < 10; k++) begin
        hc[k] = ((k * 37 + m * 11) % 200) - 100;
        wr(k, hc[k]);
      end
      for (int j = 0; j < 20; j++) push(0, "R2 flush");
      push(100, "R1 impulse");
      for (int j = 0; j < 20; j++) push(0, "R2 impulse tail");
      for (int j = 0; j < 25; j++) push(((j * 73 + m * 29) % 512) - 256, "R1 stream");
    end

    // R2 out-of-range address is ignored
    mode = 2'd2;
    for (int a = 10; a < 16; a++) wr(a, 127);
    for (int j = 0; j < 4; j++) push(200 - j * 90, "R2 ignored address");

    // R3 rounding at the half point
    for (int k = 0; k < 10; k++) begin hc[k] = (k == 0) ? 1 : 0; wr(k, hc[k]); end
    for (int j = 0; j < 20; j++) push(0, "R3 flush");
    push(63, "R3 round down");
    push(64, "R3 round up");
    push(-65, "R3 negative");
    push(-64, "R3 negative half");

    // R3 saturation at both ends
    for (int k = 0; k < 10; k++) begin hc[k] = 127; wr(k, 127); end
    for (int j = 0; j < 20; j++) push(255, "R3 positive clamp");
    chk("R3 clamp high", cap[0], 255);
    for (int j = 0; j < 20; j++) push(-256, "R3 negative clamp");
    chk("R3 clamp low", cap[0], -256);

    // R5 disabled strobe is ignored
    for (int k = 0; k < 10; k++) begin hc[k] = (k * 13) % 40 - 20; wr(k, hc[k]); end
    for (int j = 0; j < 6; j++) push(j * 40 - 100, "R5 prefill");
    for (int i = 0; i < 3; i++) begin b[i] = vcnt[i]; keep[i] = od[i]; end
    en = 0;
    @(negedge clk); in_valid = 1; in_data = 9'(177);
    @(negedge clk); in_valid = 0;
    repeat (14) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R5 no pulse", vcnt[i] - b[i], 0);
      chk("R5 output held", int'(od[i]), keep[i]);
    end
    en = 1;
    push(-33, "R5 line held");

    // R6 strobe while busy is dropped and flagged
    for (int i = 0; i < 3; i++) b[i] = vcnt[i];
    @(negedge clk); in_valid = 1; in_data = 9'(90);
    @(negedge clk); in_valid = 0;
    hist_push(90);
    repeat (2) @(negedge clk);
    in_valid = 1; in_data = 9'(-200);
    @(negedge clk); in_valid = 0;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R6 overrun set", int'(ovr[i]), 1);
      chk("R6 single pulse", vcnt[i] - b[i], 1);
      chk("R6 first result", cap[i], model(ntaps(i, int'(mode))));
    end
    push(55, "R6 dropped sample");
    for (int i = 0; i < 3; i++) chk("R6 sticky", int'(ovr[i]), 1);

    // R8 reset clears the flag and the output
    do_reset();
    for (int i = 0; i < 3; i++) begin
      chk("R8 overrun cleared", int'(ovr[i]), 0);
      chk("R8 output cleared", int'(od[i]), 0);
    end
    push(120, "R8 zero coefficients");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule